// File: doc/BRIEF.md
# Four-Phase Host Bus Interface

This block sits between a synchronous host bus and a bank of internal registers. It watches an active-low chip select on every rising edge of the system clock. Each read or write it accepts runs as a fixed internal cycle of four clock periods, C1 to C4. Address, direction and write data are latched on the edge that opens C1. The register strobe for the access is issued in C3. The active-low data acknowledge is driven in C4, and read data is registered at the end of C3, so it is valid for the whole of C4.

The bit-7 region split divides the 8-bit address space into a data region and a control region. The strobes carry the lower seven address bits. A mode input chooses between two modes. In single-access mode one chip-select assertion gives exactly one access. In burst mode accesses follow one another every four clocks for as long as chip select stays low. The mode is sampled only while the interface is idle. If chip select is released, all activity stops at once, and an access cut short before C4 neither writes nor acknowledges.

The state machine has six states: IDLE, C1, C2, C3, C4 and HOLD. It has these transitions:
- START: IDLE to C1.
- STEP: C1 to C2, C2 to C3, and C3 to C4.
- REPEAT: C4 to C1 in burst mode.
- PARK: C4 to HOLD in single mode.
- ABORT: from any state to IDLE when chip select is seen high.

Top module: `hbi_top`

## Requirements
- R1: When `cs_n` is sampled low at a rising edge while the interface is in IDLE, phase C1 begins. C2, C3 and C4 then follow on the next three edges while `cs_n` stays low.
- R2: `dack_n` is low only during C4 while `cs_n` is low. It is high at every other time, including reset.
- R3: `rw`=0 means write, and it is sampled together with `addr` and `wdata` on the edge that opens C1. A write gives exactly one strobe, held for one cycle in C3. During that strobe `reg_addr` equals `addr[6:0]` and `reg_wdata` equals the sampled `wdata`.
- R4: `rw`=1 means read. A read gives one read strobe in C3. `host_rdata` takes the addressed region's read data at the edge that ends C3, and it holds that value until the next completed read.
- R5: `addr[7]`=0 selects the data region (`data_wr`/`data_rd`) and `addr[7]`=1 selects the control region (`ctrl_wr`/`ctrl_rd`). At most one strobe is active at a time.
- R6: `burst_mode`=0 is single mode. After C4 the interface stays in HOLD while `cs_n` is low, giving no strobe and no acknowledge, and returns to IDLE only once `cs_n` is seen high.
- R7: `burst_mode`=1 is burst mode. While `cs_n` stays low, the edge after C4 opens a new C1 and re-samples `addr`, `rw` and `wdata`, so an access completes every four clocks.
- R8: A high `cs_n` removes every strobe and `dack_n` within the same cycle, without waiting for an edge. The next edge returns the interface to IDLE. An access released before C4 writes nothing and is not acknowledged.
- R9: `burst_mode` is sampled only in IDLE. Changing it during an access or in HOLD has no effect until `cs_n` has gone high and a new assertion starts.
- R10: After reset the interface is in IDLE with `dack_n` high, all strobes low and `host_rdata` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rw | input | 1 | 1 = read, 0 = write |
| burst_mode | input | 1 | 1 = burst, 0 = single access |
| addr | input | 8 | Host address; bit 7 selects the region |
| wdata | input | 8 | Host write data |
| data_rdata | input | 8 | Read data from the data region |
| ctrl_rdata | input | 8 | Read data from the control region |
| dack_n | output | 1 | Active-low data acknowledge, in C4 |
| reg_addr | output | 7 | Register address within the region |
| reg_wdata | output | 8 | Latched write data |
| data_wr | output | 1 | Data-region write strobe |
| data_rd | output | 1 | Data-region read strobe |
| ctrl_wr | output | 1 | Control-region write strobe |
| ctrl_rd | output | 1 | Control-region read strobe |
| host_rdata | output | 8 | Registered read data, valid in C4 |

## Verification
The bench drives `cs_n`, `addr`, `rw` and `wdata` on a falling edge, so the next rising edge opens C1. It then counts falling edges from that point. The third falling edge lies inside C3, where the strobe, `reg_addr` and `reg_wdata` are checked. The fourth lies inside C4, where `dack_n` must be low and `host_rdata` must hold the expected read value. When an access is aborted, the bench raises `cs_n` and checks the strobes and acknowledge one time unit later, within the same cycle. It then watches several more falling edges to confirm that nothing follows. The expected read values come from an arithmetic pattern written earlier to all 256 addresses and read back in a single burst.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_C1   = 3'd1,
        PH_C2   = 3'd2,
        PH_C3   = 3'd3,
        PH_C4   = 3'd4,
        PH_HOLD = 3'd5
    } phase_t;

endpackage

// File: rtl/hbi_seq.sv
module hbi_seq
    import hbi_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cs_n,
    input  logic   burst_mode,
    output phase_t phase,
    output logic   burst_lat,
    output logic   load
);

    phase_t phase_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nx;
        end
    end

    // mode register: follows the input only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_lat <= 1'b0;
        end else if (phase == PH_IDLE) begin
            burst_lat <= burst_mode;
        end
    end

    always_comb begin
        phase_nx = phase;
        if (cs_n) begin
            phase_nx = PH_IDLE;                       // ABORT / release
        end else begin
            unique case (phase)
                PH_IDLE: phase_nx = PH_C1;            // START
                PH_C1:   phase_nx = PH_C2;            // STEP
                PH_C2:   phase_nx = PH_C3;            // STEP
                PH_C3:   phase_nx = PH_C4;            // STEP
                PH_C4:   phase_nx = burst_lat ? PH_C1 : PH_HOLD; // REPEAT / PARK
                PH_HOLD: phase_nx = PH_HOLD;
                default: phase_nx = PH_IDLE;
            endcase
        end
    end

    assign load = (phase_nx == PH_C1);

    a_r1_c1_to_c2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_C1 && !cs_n) |=> phase == PH_C2);
    a_r1_c2_to_c3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_C2 && !cs_n) |=> phase == PH_C3);
    a_r1_c3_to_c4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_C3 && !cs_n) |=> phase == PH_C4);
    a_r8_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> phase == PH_IDLE);
    a_r6_single_park: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_C4 && !cs_n && !burst_lat) |=> phase == PH_HOLD);
    a_r7_burst_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_C4 && !cs_n && burst_lat) |=> phase == PH_C1);
    a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> $stable(burst_lat));

endmodule

// File: rtl/hbi_capture.sv
module hbi_capture
    import hbi_pkg::*;
#(
    parameter int   ADDR_W          = 8,
    parameter int   DATA_W          = 8,
    parameter logic DATA_REGION_MSB = 1'b0,
    localparam int  REG_AW          = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  logic              load,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              rw_lat,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              is_ctrl
);

    logic              msb_lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rw_lat    <= 1'b0;
            msb_lat   <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
        end else if (load) begin
            rw_lat    <= rw;
            msb_lat   <= addr[ADDR_W-1];
            reg_addr  <= addr[REG_AW-1:0];
            reg_wdata <= wdata;
        end
    end

    generate
        if (DATA_REGION_MSB) begin : g_data_high
            assign is_ctrl = ~msb_lat;
        end else begin : g_data_low
            assign is_ctrl = msb_lat;
        end
    endgenerate

    a_r3_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_C2 || phase == PH_C3 || phase == PH_C4)
            |-> $stable({rw_lat, msb_lat, reg_addr, reg_wdata}));

endmodule

// File: rtl/hbi_rdreg.sv
module hbi_rdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              is_ctrl,
    input  logic [DATA_W-1:0] data_rdata,
    input  logic [DATA_W-1:0] ctrl_rdata,
    output logic [DATA_W-1:0] host_rdata
);

    logic [DATA_W-1:0] sel;

    always_comb begin
        sel = is_ctrl ? ctrl_rdata : data_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (cap) begin
            host_rdata <= sel;
        end
    end

    a_r4_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(host_rdata));

endmodule

// File: rtl/hbi_top.sv
module hbi_top
    import hbi_pkg::*;
#(
    parameter int   ADDR_W          = 8,
    parameter int   DATA_W          = 8,
    parameter logic DATA_REGION_MSB = 1'b0,
    localparam int  REG_AW          = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rw,
    input  logic              burst_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] data_rdata,
    input  logic [DATA_W-1:0] ctrl_rdata,
    output logic              dack_n,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              data_wr,
    output logic              data_rd,
    output logic              ctrl_wr,
    output logic              ctrl_rd,
    output logic [DATA_W-1:0] host_rdata
);

    phase_t phase;
    logic   burst_lat;
    logic   load;
    logic   rw_lat;
    logic   is_ctrl;
    logic   live_c3;
    logic   rd_cap;

    hbi_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .burst_mode (burst_mode),
        .phase      (phase),
        .burst_lat  (burst_lat),
        .load       (load)
    );

    hbi_capture #(
        .ADDR_W          (ADDR_W),
        .DATA_W          (DATA_W),
        .DATA_REGION_MSB (DATA_REGION_MSB)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .load      (load),
        .rw        (rw),
        .addr      (addr),
        .wdata     (wdata),
        .rw_lat    (rw_lat),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .is_ctrl   (is_ctrl)
    );

    hbi_rdreg #(
        .DATA_W (DATA_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap        (rd_cap),
        .is_ctrl    (is_ctrl),
        .data_rdata (data_rdata),
        .ctrl_rdata (ctrl_rdata),
        .host_rdata (host_rdata)
    );

    // output process: gated by chip select so release acts at once
    always_comb begin
        live_c3 = (phase == PH_C3) && !cs_n;
        dack_n  = !((phase == PH_C4) && !cs_n);
        data_wr = live_c3 && !rw_lat && !is_ctrl;
        ctrl_wr = live_c3 && !rw_lat &&  is_ctrl;
        data_rd = live_c3 &&  rw_lat && !is_ctrl;
        ctrl_rd = live_c3 &&  rw_lat &&  is_ctrl;
        rd_cap  = live_c3 &&  rw_lat;
    end

    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_wr, ctrl_wr, data_rd, ctrl_rd}));
    a_r2_ack_after_c3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dack_n) |-> $past(phase) == PH_C3);
    a_r8_no_ack_off_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE || phase == PH_HOLD) |-> dack_n);

endmodule

// File: tb/tb_hbi_top.sv
module tb_hbi_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       rw = 1'b1;
    logic       burst_mode = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] data_rdata;
    logic [7:0] ctrl_rdata;
    logic       dack_n;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       data_wr, data_rd, ctrl_wr, ctrl_rd;
    logic [7:0] host_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] last_rd = '0;
    bit done = 0;

    logic [7:0] dmem [0:127];
    logic [7:0] cmem [0:127];

    always #(CLK_PERIOD/2) clk = ~clk;

    hbi_top dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw),
        .burst_mode(burst_mode), .addr(addr), .wdata(wdata),
        .data_rdata(data_rdata), .ctrl_rdata(ctrl_rdata),
        .dack_n(dack_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .data_wr(data_wr), .data_rd(data_rd), .ctrl_wr(ctrl_wr),
        .ctrl_rd(ctrl_rd), .host_rdata(host_rdata)
    );

    // register bank model driven only by the strobes at the ports
    assign data_rdata = dmem[reg_addr];
    assign ctrl_rdata = cmem[reg_addr];
    always @(posedge clk) begin
        if (data_wr) dmem[reg_addr] <= reg_wdata;
        if (ctrl_wr) cmem[reg_addr] <= reg_wdata;
    end

    function automatic logic [7:0] pat(input int a);
        pat = 8'((a * 7 + 3) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [3:0] strobes;
        strobes = {data_wr, ctrl_wr, data_rd, ctrl_rd};
    endfunction

    // expects cs_n low and inputs just driven at a falling edge
    task automatic run_phases(input logic rw_i, input logic [7:0] a,
                              input logic [7:0] wd, input logic [7:0] exp_rd,
                              input int flip_at);
        logic [3:0] exp_s;
        exp_s = {!rw_i && !a[7], !rw_i && a[7], rw_i && !a[7], rw_i && a[7]};
        for (int ph = 1; ph <= 4; ph++) begin
            @(negedge clk);
            if (ph < 3) begin
                chk(dack_n == 1'b1, "R1 no ack before C4", dack_n, 1);
                chk(strobes() == 4'b0, "R1 no strobe in C1/C2", strobes(), 0);
            end else if (ph == 3) begin
                chk(strobes() == exp_s, "R5 region strobe in C3", strobes(), exp_s);
                chk(reg_addr == a[6:0], "R3 reg_addr in C3", reg_addr, a[6:0]);
                if (!rw_i) chk(reg_wdata == wd, "R3 reg_wdata in C3", reg_wdata, wd);
                chk(dack_n == 1'b1, "R2 no ack in C3", dack_n, 1);
            end else begin
                chk(dack_n == 1'b0, "R2 ack in C4", dack_n, 0);
                chk(strobes() == 4'b0, "R3 single strobe cycle", strobes(), 0);
                if (rw_i) begin
                    chk(host_rdata == exp_rd, "R4 read data in C4", host_rdata, exp_rd);
                    last_rd = exp_rd;
                end else begin
                    chk(host_rdata == last_rd, "R4 read data held", host_rdata, last_rd);
                end
            end
            if (ph == flip_at) burst_mode = ~burst_mode;
        end
    endtask

    task automatic single(input logic rw_i, input logic [7:0] a, input logic [7:0] wd,
                          input logic [7:0] exp_rd, input int flip_at, input int hold_n);
        @(negedge clk);
        cs_n = 1'b0; rw = rw_i; addr = a; wdata = wd;
        run_phases(rw_i, a, wd, exp_rd, flip_at);
        for (int h = 0; h < hold_n; h++) begin
            @(negedge clk);
            chk(dack_n == 1'b1 && strobes() == 4'b0, "R6 hold quiet",
                {dack_n, strobes()}, 5'b10000);
        end
        cs_n = 1'b1;
        @(negedge clk);
        chk(dack_n == 1'b1, "R2 ack high after release", dack_n, 1);
    endtask

    task automatic abort_at(input logic rw_i, input logic [7:0] a,
                            input logic [7:0] wd, input int p);
        @(negedge clk);
        cs_n = 1'b0; rw = rw_i; addr = a; wdata = wd;
        for (int ph = 1; ph <= p; ph++) @(negedge clk);
        cs_n = 1'b1;
        #1;
        chk(dack_n == 1'b1 && strobes() == 4'b0, "R8 immediate release",
            {dack_n, strobes()}, 5'b10000);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(dack_n == 1'b1 && strobes() == 4'b0, "R8 nothing after abort",
                {dack_n, strobes()}, 5'b10000);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        for (int i = 0; i < 128; i++) begin
            dmem[i] = '0;
            cmem[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(dack_n == 1'b1, "R10 reset ack", dack_n, 1);
        chk(strobes() == 4'b0, "R10 reset strobes", strobes(), 0);
        chk(host_rdata == 8'h00, "R10 reset rdata", host_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dack_n == 1'b1 && strobes() == 4'b0, "R10 idle after reset",
            {dack_n, strobes()}, 5'b10000);

        // R3 R5 R6: single writes to every address
        burst_mode = 1'b0;
        for (int a = 0; a < 256; a++) single(1'b0, 8'(a), pat(a), 8'h00, 0, 2);

        // R7 R4: one burst reading every address
        burst_mode = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        for (int a = 0; a < 256; a++) begin
            rw = 1'b1; addr = 8'(a);
            run_phases(1'b1, 8'(a), 8'h00, pat(a), 0);
        end
        cs_n = 1'b1;
        @(negedge clk);

        // R8: aborted writes leave the registers untouched
        burst_mode = 1'b0;
        abort_at(1'b0, 8'h21, 8'hEE, 3);
        abort_at(1'b0, 8'hA2, 8'hEE, 2);
        abort_at(1'b0, 8'h13, 8'hEE, 1);
        abort_at(1'b1, 8'h33, 8'h00, 4);
        single(1'b1, 8'h21, 8'h00, pat(8'h21), 0, 1);
        single(1'b1, 8'hA2, 8'h00, pat(8'hA2), 0, 1);
        single(1'b1, 8'h13, 8'h00, pat(8'h13), 0, 1);

        // R9: turning burst on mid-access must not repeat the access
        burst_mode = 1'b0;
        single(1'b0, 8'h44, 8'h5C, 8'h00, 2, 9);
        // mode is now 1 and takes effect on the next assertion: R7
        @(negedge clk);
        cs_n = 1'b0;
        rw = 1'b0; addr = 8'h45; wdata = 8'h61;
        run_phases(1'b0, 8'h45, 8'h61, 8'h00, 1);   // R9 turn burst off mid-burst
        rw = 1'b0; addr = 8'hC5; wdata = 8'h62;
        run_phases(1'b0, 8'hC5, 8'h62, 8'h00, 0);
        rw = 1'b1; addr = 8'h44;
        run_phases(1'b1, 8'h44, 8'h00, 8'h5C, 0);
        rw = 1'b1; addr = 8'hC5;
        run_phases(1'b1, 8'hC5, 8'h00, 8'h62, 0);
        cs_n = 1'b1;
        @(negedge clk);
        single(1'b1, 8'h45, 8'h00, 8'h61, 0, 2);
        // R4: a write leaves host_rdata at the last read value
        single(1'b0, 8'h46, 8'h77, 8'h00, 0, 1);
        chk(host_rdata == 8'h61, "R4 rdata kept across write", host_rdata, 8'h61);

        report();
    end

endmodule